// File: doc/BRIEF.md
# Serial NOR Flash Slave Model

This block is a synthesizable SPI mode-0 slave that answers like a small serial NOR flash. It is placed next to a flash controller under test, on an FPGA or in simulation, so that the controller's erase, program and read sequences run against a target that keeps real flash rules. The array is a byte RAM whose size is set by a parameter. Address bits above that size are dropped, so the small array stands in for a much larger device and repeats across its address space.

The four pins are sampled with the system clock. Chip select, serial clock and the data input each pass through a two-stage synchronizer. Edges are then found by comparing each synchronized level with its value one cycle earlier, so the serial clock must run well below the system clock. Write enable, chip erase and page program are decoded byte by byte. Their effect is applied only when chip select rises. Program data is first collected in a one-page buffer and is then merged into the array with AND semantics by a short sweep. Chip erase runs as a sweep that writes 0xFF to every address. A read starts streaming array bytes as soon as its address is complete.

Top module: `spi_flash_emu`

## Requirements
- R1: Bytes on `mosi` are taken MSB first on the rising edge of `sck`. Read (opcode 0x03) is followed by a 3-byte address, most significant byte first. It then returns array bytes from consecutive addresses, MSB first, with each `miso` bit changed after a falling `sck` edge. Reading carries on across page boundaries and wraps from the last array byte to byte 0.
- R2: `miso` is 0 while `cs_n` is high, during reset, and in every frame before a read's data phase.
- R3: Write enable (opcode 0x06) sets the write-enable latch when `cs_n` rises on a whole-byte boundary.
- R4: Chip erase (opcode 0xC7), accepted with the latch set, makes every array byte read 0xFF. This holds no later than DEPTH+16 clock cycles after `cs_n` rises.
- R5: Page program (opcode 0x02) takes a 3-byte address and then data bytes. Each addressed byte becomes its old value AND the new byte, so a 1 in the data leaves the stored bit as it was.
- R6: Chip erase and page program change nothing when the write-enable latch is clear.
- R7: Inside a program frame the low address byte advances per data byte and wraps from 0xFF to 0x00. The upper address bits stay fixed, so no byte outside the addressed 256-byte page changes.
- R8: If `cs_n` rises part-way through a byte, the whole frame is discarded. A cut write enable does not set the latch. A cut erase or program changes no byte and leaves the latch set.
- R9: Address bits at and above log2(DEPTH) are ignored for both program and read.
- R10: An accepted erase or program clears the write-enable latch, so a further erase or program without a new write enable is ignored.
- R11: A program frame that ends right after its address, with no data byte, is not accepted and leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are oversampled with it |
| rst | input | 1 | Synchronous active-high reset; does not clear the array |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 (idle low) |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller, registered |

## Verification
The hardest situation to reach from the pins is a frame that is correct up to some point and then loses chip select in the middle of a byte. The check is not only that no array byte changes. The latch must also still be set, or still be clear, afterwards. The bench drives the serial lines one bit at a time, so it can end a frame after any number of bits. It then probes the hidden latch with a program frame that carries no new write enable. The data it reads back shows whether that program was accepted. The same probe covers a program with an address but no data, and the clearing of the latch after an accepted operation. In-page wrap, the AND merge and aliasing each use data patterns whose expected bytes the bench works out itself.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ERASE = 8'hC7;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  // Offset width inside one program page (256 bytes).
  localparam int PAGE_AW = 8;
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_PROG  = 2'd2,
    ST_DRAIN = 2'd3
  } store_state_e;
endpackage

// File: rtl/sfe_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a bundle of asynchronous pins.
module sfe_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= din;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sfe_frame.sv
`timescale 1ns/1ps
// Frame decoder: serial shift, opcode/address capture, latch, read stream.
module sfe_frame
  import sfe_pkg::*;
#(
  parameter int AW = 9,
  localparam int PGW = AW - PAGE_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_s,
  input  logic               sck_s,
  input  logic               mosi_s,
  input  logic               busy,
  input  logic [7:0]         ram_q,
  output logic [AW-1:0]      rd_addr,
  output logic               buf_clr,
  output logic               buf_we,
  output logic [PAGE_AW-1:0] buf_waddr,
  output logic [7:0]         buf_wdata,
  output logic               erase_go,
  output logic               prog_go,
  output logic [PGW-1:0]     prog_page,
  output logic               wel,
  output logic               miso
);
  logic               cs_q, sck_q;
  logic               active, rd_on;
  logic [2:0]         bitcnt, nbytes;
  logic [7:0]         rx_sr, cmd, tx_sr;
  logic [PGW-1:0]     addr_pg;
  logic [PAGE_AW-1:0] pg_off;

  wire cs_fall  = cs_q & ~cs_s;
  wire cs_rise  = ~cs_q & cs_s;
  wire sck_rise = ~sck_q & sck_s;
  wire sck_fall = sck_q & ~sck_s;
  wire [7:0] rx_byte = {rx_sr[6:0], mosi_s};
  wire whole_frame = active && (bitcnt == 3'd0) && (nbytes != 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      active    <= 1'b0;
      rd_on     <= 1'b0;
      bitcnt    <= '0;
      nbytes    <= '0;
      rx_sr     <= '0;
      cmd       <= '0;
      tx_sr     <= '0;
      addr_pg   <= '0;
      pg_off    <= '0;
      rd_addr   <= '0;
      buf_clr   <= 1'b0;
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
      erase_go  <= 1'b0;
      prog_go   <= 1'b0;
      prog_page <= '0;
      wel       <= 1'b0;
      miso      <= 1'b0;
    end else begin
      cs_q     <= cs_s;
      sck_q    <= sck_s;
      buf_clr  <= 1'b0;
      buf_we   <= 1'b0;
      erase_go <= 1'b0;
      prog_go  <= 1'b0;
      if (cs_fall && !busy) begin
        active  <= 1'b1;
        rd_on   <= 1'b0;
        bitcnt  <= '0;
        nbytes  <= '0;
        buf_clr <= 1'b1;
      end else if (cs_rise) begin
        active <= 1'b0;
        rd_on  <= 1'b0;
        miso   <= 1'b0;
        if (whole_frame) begin
          if (cmd == OP_WREN) begin
            wel <= 1'b1;
          end else if (cmd == OP_ERASE && wel) begin
            erase_go <= 1'b1;
            wel      <= 1'b0;
          end else if (cmd == OP_PROG && wel && nbytes == 3'd5) begin
            prog_go <= 1'b1;
            wel     <= 1'b0;
          end
        end
      end else if (active && !cs_s) begin
        if (sck_rise) begin
          rx_sr  <= rx_byte;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            if (nbytes != 3'd5) nbytes <= nbytes + 3'd1;
            case (nbytes)
              3'd0: cmd <= rx_byte;
              3'd1, 3'd2: addr_pg <= PGW'({addr_pg, rx_byte});
              3'd3: begin
                pg_off    <= rx_byte;
                prog_page <= addr_pg;
                if (cmd == OP_READ) begin
                  rd_on   <= 1'b1;
                  rd_addr <= {addr_pg, rx_byte};
                end
              end
              default: begin
                if (cmd == OP_PROG) begin
                  buf_we    <= 1'b1;
                  buf_waddr <= pg_off;
                  buf_wdata <= rx_byte;
                  pg_off    <= pg_off + PAGE_AW'(1);
                end
              end
            endcase
          end
        end
        if (sck_fall && rd_on) begin
          if (bitcnt == 3'd0) begin
            miso    <= ram_q[7];
            tx_sr   <= {ram_q[6:0], 1'b0};
            rd_addr <= rd_addr + AW'(1);
          end else begin
            miso  <= tx_sr[7];
            tx_sr <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfe_page_buf.sv
`timescale 1ns/1ps
// One-page staging buffer with per-byte "written" flags.
module sfe_page_buf
  import sfe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               we,
  input  logic [PAGE_AW-1:0] waddr,
  input  logic [7:0]         wdata,
  input  logic [PAGE_AW-1:0] raddr,
  output logic [7:0]         rdata,
  output logic               rvalid
);
  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] flags;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (we) flags[waddr] <= 1'b1;
      rvalid <= flags[raddr];
    end
  end
endmodule

// File: rtl/sfe_store.sv
`timescale 1ns/1ps
// Byte array plus the erase and page-merge sweeps.
module sfe_store
  import sfe_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW = 9,
  localparam int PGW = AW - PAGE_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               erase_go,
  input  logic               prog_go,
  input  logic [PGW-1:0]     prog_page,
  input  logic [AW-1:0]      rd_addr,
  input  logic [7:0]         buf_rdata,
  input  logic               buf_rvalid,
  output logic [7:0]         ram_q,
  output logic [PAGE_AW-1:0] buf_raddr,
  output logic               busy
);
  store_state_e       state;
  logic [AW-1:0]      cnt;
  logic [PGW-1:0]     pg;
  logic [PAGE_AW-1:0] off_d;
  logic               pend;
  logic [7:0]         mem [DEPTH];
  logic               we;
  logic [AW-1:0]      waddr, raddr;
  logic [7:0]         wdata;

  assign busy      = (state != ST_IDLE);
  assign buf_raddr = cnt[PAGE_AW-1:0];

  always_comb begin
    we    = 1'b0;
    waddr = {pg, off_d};
    wdata = ram_q & buf_rdata;
    if (state == ST_ERASE) begin
      we    = 1'b1;
      waddr = cnt;
      wdata = 8'hFF;
    end else if (pend && buf_rvalid) begin
      we = 1'b1;
    end
    raddr = (state == ST_PROG) ? {pg, cnt[PAGE_AW-1:0]} : rd_addr;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ram_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pg    <= '0;
      off_d <= '0;
      pend  <= 1'b0;
    end else begin
      pend  <= (state == ST_PROG);
      off_d <= cnt[PAGE_AW-1:0];
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (erase_go) begin
            state <= ST_ERASE;
          end else if (prog_go) begin
            state <= ST_PROG;
            pg    <= prog_page;
          end
        end
        ST_ERASE: begin
          cnt <= cnt + AW'(1);
          if (cnt == AW'(DEPTH - 1)) state <= ST_IDLE;
        end
        ST_PROG: begin
          cnt <= cnt + AW'(1);
          if (cnt[PAGE_AW-1:0] == '1) state <= ST_DRAIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_emu.sv
`timescale 1ns/1ps
module spi_flash_emu
  import sfe_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PGW = AW - PAGE_AW
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic [2:0]         pins_s;
  logic [AW-1:0]      rd_addr;
  logic               buf_clr, buf_we, buf_rvalid;
  logic [PAGE_AW-1:0] buf_waddr, buf_raddr;
  logic [7:0]         buf_wdata, buf_rdata, ram_q;
  logic               erase_go, prog_go, wel, busy;
  logic [PGW-1:0]     prog_page;

  sfe_sync #(.W(3), .RST_VAL(3'b100)) sync_i (
    .clk (clk),
    .rst (rst),
    .din ({cs_n, sck, mosi}),
    .q   (pins_s)
  );

  sfe_frame #(.AW(AW)) frame_i (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (pins_s[2]),
    .sck_s     (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .busy      (busy),
    .ram_q     (ram_q),
    .rd_addr   (rd_addr),
    .buf_clr   (buf_clr),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata),
    .erase_go  (erase_go),
    .prog_go   (prog_go),
    .prog_page (prog_page),
    .wel       (wel),
    .miso      (miso)
  );

  sfe_page_buf pbuf_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (buf_clr),
    .we     (buf_we),
    .waddr  (buf_waddr),
    .wdata  (buf_wdata),
    .raddr  (buf_raddr),
    .rdata  (buf_rdata),
    .rvalid (buf_rvalid)
  );

  sfe_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk        (clk),
    .rst        (rst),
    .erase_go   (erase_go),
    .prog_go    (prog_go),
    .prog_page  (prog_page),
    .rd_addr    (rd_addr),
    .buf_rdata  (buf_rdata),
    .buf_rvalid (buf_rvalid),
    .ram_q      (ram_q),
    .buf_raddr  (buf_raddr),
    .busy       (busy)
  );
endmodule

// File: rtl/sfe_checker.sv
`timescale 1ns/1ps
module sfe_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic miso,
  input logic wel,
  input logic erase_go,
  input logic prog_go,
  input logic busy,
  input logic buf_we
);
  a_r2_miso_quiet: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (miso == 1'b0));

  a_r6_go_needs_latch: assert property (@(posedge clk) disable iff (rst)
    (erase_go || prog_go) |-> $past(wel));

  a_r10_latch_dropped: assert property (@(posedge clk) disable iff (rst)
    (erase_go || prog_go) |-> !wel);

  a_r4_go_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_go, prog_go}));

  a_r4_sweep_starts: assert property (@(posedge clk) disable iff (rst)
    (erase_go || prog_go) |=> busy);

  a_r5_no_capture_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !buf_we);
endmodule

bind spi_flash_emu sfe_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .miso     (miso),
  .wel      (wel),
  .erase_go (erase_go),
  .prog_go  (prog_go),
  .busy     (busy),
  .buf_we   (buf_we)
);

// File: tb/spi_flash_emu_tb_top.sv
`timescale 1ns/1ps
module spi_flash_emu_tb_top;
  localparam int DEPTH = 512;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  spi_flash_emu #(.DEPTH(DEPTH)) dut_i (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .sck  (sck),
    .mosi (mosi),
    .miso (miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    mosi = b;
    wait_clk(H);
    r = miso;
    sck = 1'b1;
    wait_clk(H);
    sck = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      xfer_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic frame_begin();
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic frame_end();
    wait_clk(H);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(4 * H);
    chk(miso === 1'b0, "R2", "miso with cs_n high", int'(miso), 0);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] rx;
    xfer_byte(a[23:16], rx);
    xfer_byte(a[15:8], rx);
    xfer_byte(a[7:0], rx);
  endtask

  task automatic do_wren();
    logic [7:0] rx;
    frame_begin();
    xfer_byte(8'h06, rx);
    chk(rx === 8'h00, "R2", "miso during opcode", int'(rx), 0);
    frame_end();
  endtask

  task automatic do_erase(input bit applies);
    logic [7:0] rx;
    frame_begin();
    xfer_byte(8'hC7, rx);
    frame_end();
    wait_clk(DEPTH + 16);
    if (applies) for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  task automatic do_prog(input logic [23:0] a, input int n,
                         input logic [31:0] d, input bit applies);
    logic [7:0] rx;
    frame_begin();
    xfer_byte(8'h02, rx);
    send_addr(a);
    for (int i = 0; i < n; i++) xfer_byte(d[31-8*i -: 8], rx);
    frame_end();
    wait_clk(300);
    if (applies) begin
      for (int i = 0; i < n; i++) begin
        int idx;
        idx = ((int'(a) & ~255) | ((int'(a[7:0]) + i) & 255)) & (DEPTH - 1);
        model[idx] = model[idx] & d[31-8*i -: 8];
      end
    end
  endtask

  task automatic read_check(input logic [23:0] a, input int n, input string req);
    logic [7:0] rx;
    frame_begin();
    xfer_byte(8'h03, rx);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = (int'(a) + i) & (DEPTH - 1);
      xfer_byte(8'h00, rx);
      chk(rx === model[idx], req, $sformatf("read byte at 0x%0h", idx),
          int'(rx), int'(model[idx]));
    end
    frame_end();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    wait_clk(8);
    rst = 1'b0;
    wait_clk(4);
    chk(miso === 1'b0, "R2", "miso after reset", int'(miso), 0);

    // R3, R4: write enable then chip erase; whole array reads 0xFF (R1 stream)
    do_wren();
    do_erase(1'b1);
    read_check(24'h000000, DEPTH, "R4");

    // R6: program without the latch does nothing
    do_prog(24'h000010, 4, 32'h00000000, 1'b0);
    read_check(24'h000010, 4, "R6");

    // R5 / R3: accepted program merges with AND
    do_wren();
    do_prog(24'h000010, 4, 32'hA53C0FF0, 1'b1);
    read_check(24'h00000E, 8, "R5");

    // R10: latch cleared by the accepted program
    do_prog(24'h000010, 4, 32'hFFC3F00F, 1'b0);
    read_check(24'h000010, 4, "R10");

    // R5: ones in the data never set stored bits
    do_wren();
    do_prog(24'h000010, 4, 32'hFFC3F00F, 1'b1);
    read_check(24'h000010, 4, "R5");

    // R7: offset wraps inside page 0; page 1 untouched; R1 read crosses pages
    do_wren();
    do_prog(24'h0000FE, 4, 32'h11223344, 1'b1);
    read_check(24'h0000FC, 8, "R7");
    read_check(24'h0000FC, 8, "R1");

    // R8: program cut mid-byte is discarded, latch survives
    do_wren();
    frame_begin();
    xfer_byte(8'h02, rx);
    send_addr(24'h000040);
    xfer_byte(8'h00, rx);
    for (int i = 0; i < 3; i++) begin
      logic r;
      xfer_bit(1'b0, r);
    end
    frame_end();
    wait_clk(300);
    read_check(24'h000040, 1, "R8");
    do_prog(24'h000040, 1, 32'h81000000, 1'b1);
    read_check(24'h000040, 1, "R8");

    // R8: write enable cut after five bits does not set the latch
    frame_begin();
    for (int i = 0; i < 5; i++) begin
      logic r;
      xfer_bit(1'b0, r);
    end
    frame_end();
    do_prog(24'h000041, 1, 32'h00000000, 1'b0);
    read_check(24'h000041, 1, "R8");

    // R11: program with no data byte keeps the latch
    do_wren();
    frame_begin();
    xfer_byte(8'h02, rx);
    send_addr(24'h000050);
    frame_end();
    wait_clk(300);
    do_prog(24'h000050, 1, 32'h77000000, 1'b1);
    read_check(24'h000050, 1, "R11");

    // R9: high address bits ignored for program and read
    do_wren();
    do_prog(24'h7F0120, 2, 32'h5A6B0000, 1'b1);
    read_check(24'h000120, 2, "R9");
    read_check(24'hABCD20, 2, "R9");

    // R1: read wraps from the last array byte to byte 0
    read_check(24'h0001FE, 4, "R1");

    // R6: erase without the latch leaves data in place
    do_erase(1'b0);
    read_check(24'h000010, 4, "R6");

    // R4 / R10: accepted erase, then latch found clear
    do_wren();
    do_erase(1'b1);
    read_check(24'h000000, 32, "R4");
    read_check(24'h0000F0, 32, "R4");
    do_prog(24'h000000, 1, 32'h00000000, 1'b0);
    read_check(24'h000000, 1, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule